// File: doc/BRIEF.md
# Integer ALU with Compare Flags

This block is the purely combinational integer execute unit of a small load/store processor. Two 32-bit operands and a 4-bit operation code go in. A 32-bit result, a zero flag and an overflow flag come out in the same cycle. It covers signed and unsigned add and subtract, four bitwise logic functions, and signed and unsigned set-on-less-than.

All arithmetic runs on one ripple adder. For subtraction and for both compares, the second operand is inverted and the adder carry-in is forced to one. A branch on equal or not-equal issues a subtraction and tests the zero flag. Operand extension, shifts, multiply, divide and trap handling belong to neighbouring logic.

Internally, a decoder turns the operation code into a small struct of strobes. The strobes steer a datapath that holds the adder, the logic functions and the output multiplexer.

Top module: `int_alu`

## Requirements
- R1: Code 0010 (signed add) and code 0011 (unsigned add) give `opA + opB` modulo 2^32.
- R2: Code 0110 (signed subtract) and code 1000 (unsigned subtract) give `opA - opB` modulo 2^32.
- R3: For codes 0010 and 0110, `ovf` is 1 exactly when the signed result does not fit in 32 bits. This equals the carry into bit 31 XOR the carry out of bit 31.
- R4: Codes 0011 and 1000 never assert `ovf`, whatever the operands.
- R5: Codes 0000 (AND), 0001 (OR), 0100 (XOR) and 0101 (NOR) give the bitwise function of the operands with `ovf` at 0.
- R6: Code 0111 gives 1 in bit 0 when `opA < opB` as signed numbers, and 0 otherwise. This holds even when `opA - opB` overflows. Bits 31..1 are zero and `ovf` is 0.
- R7: Code 1001 gives 1 in bit 0 when `opA < opB` as unsigned numbers, and 0 otherwise. Bits 31..1 are zero and `ovf` is 0.
- R8: For every defined code, `zero` is 1 exactly when all 32 result bits are 0. This includes a subtraction of equal operands.
- R9: Codes 1010 to 1111 give a zero result with `zero` and `ovf` both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opSel | input | 4 | Operation code |
| result | output | 32 | Selected function result |
| zero | output | 1 | Result is all zeros (defined codes only) |
| ovf | output | 1 | Signed overflow on signed add or subtract |

## Verification
The checker assumes the operands and operation code are settled, two-valued inputs. Its immediate checks evaluate after the combinational logic has settled, so an X or a mid-change input would report spurious errors.

The stimulus honours this in three ways. It changes inputs only on the falling clock edge. It samples a quarter period later. Every value comes from literals or `$urandom`, so all inputs are always two-valued.

Operands mix random words with the four boundary words (all zeros, all ones, largest positive, most negative). Operation codes cover all sixteen values, so the unused codes reach the checker as well.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 4;

  // Operation codes; the decoder and the bench both rely on these values.
  localparam logic [OP_W-1:0] OP_AND  = 4'b0000;
  localparam logic [OP_W-1:0] OP_OR   = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADD  = 4'b0010;
  localparam logic [OP_W-1:0] OP_ADDU = 4'b0011;
  localparam logic [OP_W-1:0] OP_XOR  = 4'b0100;
  localparam logic [OP_W-1:0] OP_NOR  = 4'b0101;
  localparam logic [OP_W-1:0] OP_SUB  = 4'b0110;
  localparam logic [OP_W-1:0] OP_SLT  = 4'b0111;
  localparam logic [OP_W-1:0] OP_SUBU = 4'b1000;
  localparam logic [OP_W-1:0] OP_SLTU = 4'b1001;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_NOR,
    SEL_SUM,
    SEL_LESS
  } sel_e;

  // Strobes from decoder to datapath.
  typedef struct packed {
    logic subMode;     // invert B and force carry-in
    logic ovfEn;       // signed arithmetic may flag overflow
    logic lessSigned;  // compare as signed numbers
    logic validOp;     // code is defined
    sel_e resSel;      // output multiplexer select
  } ctrl_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output ctrl_t           ctrl
);

  always_comb begin
    ctrl = '{subMode: 1'b0, ovfEn: 1'b0, lessSigned: 1'b0,
             validOp: 1'b1, resSel: SEL_ZERO};
    unique case (opSel)
      OP_AND:  ctrl.resSel = SEL_AND;
      OP_OR:   ctrl.resSel = SEL_OR;
      OP_XOR:  ctrl.resSel = SEL_XOR;
      OP_NOR:  ctrl.resSel = SEL_NOR;
      OP_ADD: begin
        ctrl.resSel = SEL_SUM;
        ctrl.ovfEn  = 1'b1;
      end
      OP_ADDU: ctrl.resSel = SEL_SUM;
      OP_SUB: begin
        ctrl.resSel  = SEL_SUM;
        ctrl.subMode = 1'b1;
        ctrl.ovfEn   = 1'b1;
      end
      OP_SUBU: begin
        ctrl.resSel  = SEL_SUM;
        ctrl.subMode = 1'b1;
      end
      OP_SLT: begin
        ctrl.resSel     = SEL_LESS;
        ctrl.subMode    = 1'b1;
        ctrl.lessSigned = 1'b1;
      end
      OP_SLTU: begin
        ctrl.resSel  = SEL_LESS;
        ctrl.subMode = 1'b1;
      end
      default: ctrl.validOp = 1'b0;
    endcase
  end

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ctrl_t            ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sumVec;
  logic [WIDTH:0]   carry;
  logic             ovfRaw;
  logic             lessBit;

  assign bEff     = opB ^ {WIDTH{ctrl.subMode}};
  assign carry[0] = ctrl.subMode;

  // Ripple chain: one full-adder cell per bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sumVec[i]  = opA[i] ^ bEff[i] ^ carry[i];
    assign carry[i+1] = (opA[i] & bEff[i]) | (opA[i] & carry[i]) |
                        (bEff[i] & carry[i]);
  end

  assign ovfRaw  = carry[MSB] ^ carry[WIDTH];
  // Signed: difference sign corrected by overflow; unsigned: no carry-out means borrow.
  assign lessBit = ctrl.lessSigned ? (sumVec[MSB] ^ ovfRaw) : ~carry[WIDTH];

  always_comb begin
    unique case (ctrl.resSel)
      SEL_AND:  result = opA & opB;
      SEL_OR:   result = opA | opB;
      SEL_XOR:  result = opA ^ opB;
      SEL_NOR:  result = ~(opA | opB);
      SEL_SUM:  result = sumVec;
      SEL_LESS: result = {{(WIDTH-1){1'b0}}, lessBit};
      default:  result = '0;
    endcase
  end

  assign zero = ctrl.validOp & ~(|result);
  assign ovf  = ctrl.ovfEn & ovfRaw;

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [OP_W-1:0]  opSel,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);

  ctrl_t ctrl;

  int_alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  int_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .ctrl   (ctrl),
    .result (result),
    .zero   (zero),
    .ovf    (ovf)
  );

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [OP_W-1:0]  opSel,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic isDefined;
  assign isDefined = (opSel <= OP_SLTU);

  always_comb begin
    // R1: add results wrap modulo 2^WIDTH
    if (opSel == OP_ADD || opSel == OP_ADDU)
      a_r1_add_sum: assert (result == opA + opB);
    // R2: subtract results wrap modulo 2^WIDTH
    if (opSel == OP_SUB || opSel == OP_SUBU)
      a_r2_sub_diff: assert (result == opA - opB);
    // R3: signed add overflows only when operand signs agree and result sign differs
    if (opSel == OP_ADD)
      a_r3_add_ovf: assert (ovf == ((opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB])));
    // R3: signed subtract overflows only when operand signs differ and result sign differs from A
    if (opSel == OP_SUB)
      a_r3_sub_ovf: assert (ovf == ((opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB])));
    // R4: unsigned arithmetic never flags
    if (opSel == OP_ADDU || opSel == OP_SUBU)
      a_r4_no_overflow: assert (!ovf);
    // R5: logic codes never flag
    if (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR || opSel == OP_NOR)
      a_r5_logic_no_ovf: assert (!ovf);
    // R6: signed compare matches signed ordering, upper bits clear
    if (opSel == OP_SLT)
      a_r6_slt: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))} && !ovf);
    // R7: unsigned compare matches unsigned ordering
    if (opSel == OP_SLTU)
      a_r7_sltu: assert (result == {{(WIDTH-1){1'b0}}, (opA < opB)} && !ovf);
    // R8: zero flag tracks an all-zero result
    if (isDefined)
      a_r8_zero_flag: assert (zero == (result == '0));
    // R9: unused codes produce nothing
    if (!isDefined)
      a_r9_unused: assert (result == '0 && !zero && !ovf);
  end

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  import int_alu_pkg::*;

  localparam int W = 32;
  localparam int NVEC = 20;
  localparam int NRAND = 3000;

  typedef struct packed {
    logic [3:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic         zf;
    logic         of;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'b0010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1}, // R3 add overflow
    '{4'b0011, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0}, // R4 addu no flag
    '{4'b0010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R1 wrap, no ovf
    '{4'b0010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1}, // R3 negative overflow
    '{4'b0110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1}, // R3 sub overflow
    '{4'b1000, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b0}, // R4 subu no flag
    '{4'b0110, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0}, // R8 equality
    '{4'b0110, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0, 1'b1}, // R3 0 - min
    '{4'b0111, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0}, // R6 overflowing diff
    '{4'b0111, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0}, // R6 overflowing diff
    '{4'b1001, 32'h00000001, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0}, // R7
    '{4'b1001, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 1'b1, 1'b0}, // R7
    '{4'b0000, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 1'b0, 1'b0}, // R5 and
    '{4'b0001, 32'hF0F0F0F0, 32'h0FF00FF0, 32'hFFF0FFF0, 1'b0, 1'b0}, // R5 or
    '{4'b0100, 32'hF0F0F0F0, 32'h0FF00FF0, 32'hFF00FF00, 1'b0, 1'b0}, // R5 xor
    '{4'b0101, 32'hFFFF0000, 32'h0000FFFF, 32'h00000000, 1'b1, 1'b0}, // R5 nor
    '{4'b1010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0}, // R9
    '{4'b1111, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0}, // R9
    '{4'b0011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b0, 1'b0}, // R1 addu carry out
    '{4'b0111, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0}  // R6 equal
  };

  localparam logic [W-1:0] CORNERS [4] = '{32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h00000000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [3:0]   opSel = 4'b0000;
  logic [W-1:0] result;
  logic         zero;
  logic         ovf;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  int_alu #(.WIDTH(W)) u_dut (
    .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .zero(zero), .ovf(ovf)
  );

  function automatic string reqTag(input logic [3:0] op);
    case (op)
      4'b0010, 4'b0011: return "R1/R3/R4";
      4'b0110, 4'b1000: return "R2/R3/R4";
      4'b0000, 4'b0001, 4'b0100, 4'b0101: return "R5";
      4'b0111: return "R6";
      4'b1001: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Behavioural reference built from the requirement text.
  task automatic refModel(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                          output logic [W-1:0] r, output logic z, output logic o);
    logic [W:0] wide;
    r = '0; o = 1'b0;
    case (op)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b0100: r = a ^ b;
      4'b0101: r = ~(a | b);
      4'b0010, 4'b0011: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[W-1:0];
        if (op == 4'b0010) o = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      4'b0110, 4'b1000: begin
        wide = {1'b0, a} - {1'b0, b};
        r = wide[W-1:0];
        if (op == 4'b0110) o = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      4'b0111: r = ($signed(a) < $signed(b)) ? 1 : 0;
      4'b1001: r = (a < b) ? 1 : 0;
      default: r = '0;
    endcase
    z = (op <= 4'b1001) && (r == '0);
  endtask

  task automatic runOne(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] er, input logic ez, input logic eo, input string tag);
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    #5;
    checks++;
    if (result !== er || zero !== ez || ovf !== eo) begin
      failures++;
      $display("FAIL %s op=%b a=%h b=%h actual res=%h z=%b o=%b expected res=%h z=%b o=%b",
               tag, op, a, b, result, zero, ovf, er, ez, eo);
    end
  endtask

  task automatic runRef(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] er;
    logic ez, eo;
    refModel(op, a, b, er, ez, eo);
    runOne(op, a, b, er, ez, eo, reqTag(op));
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset-time check: AND of zeros gives zero result with zero flag (R8, R5).
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (result !== '0 || zero !== 1'b1 || ovf !== 1'b0) begin
      failures++;
      $display("FAIL R8 reset state actual res=%h z=%b o=%b expected res=0 z=1 o=0",
               result, zero, ovf);
    end
    rst_n = 1'b1;

    // Table of directed vectors.
    for (int i = 0; i < NVEC; i++)
      runOne(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].res, VECS[i].zf, VECS[i].of,
             reqTag(VECS[i].op));

    // Corner operand cross product over every code.
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          runRef(op[3:0], CORNERS[i], CORNERS[j]);

    // Random operands, random codes.
    for (int k = 0; k < NRAND; k++)
      runRef(4'($urandom_range(15)), $urandom, $urandom);

    // Equal random operands through subtract: zero flag for branches (R8).
    for (int k = 0; k < 50; k++) begin
      logic [W-1:0] v;
      v = $urandom;
      runOne(4'b0110, v, v, '0, 1'b1, 1'b0, "R8");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule